// File: doc/BRIEF.md
# Character-Based CRTC Timing Generator

This block produces the raster timing for a single display head. A horizontal counter steps once every eight pixel-clock enables, so it counts 8-pixel characters. A vertical counter steps at the end of every line. Comparators against a set of programmed values give horizontal and vertical blanking, horizontal and vertical sync, a display-enable strobe, a line-compare flag and the current scanline number.

Software writes timing values through a small write port, one register per address. The values are stored offset-encoded: totals hold the count minus a fixed bias, and display ends hold the last visible position. Each sync end is kept as a few low bits and matched against the low bits of its counter. Timing writes go to a shadow copy, which is moved into the active copy only at the frame wrap. A polarity register and a power register take effect at once. The power register starts and stops the raster, holds each sync at its idle level for power saving, and can blank the picture while the counters keep running.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset, and whenever the run bit is clear, both counters are held at zero and hblank, vblank and disp_en are low. line_hit is low, raster_line is 0, and each sync output sits at its inactive level (low with default polarity).
- R2: While running, the character counter advances once per eight pix_ce pulses. A line lasts H_TOTAL+5 characters, with the counter going 0 to H_TOTAL+4 and then wrapping. Gaps in pix_ce stretch the line.
- R3: The line counter advances when the character counter wraps. A frame lasts V_TOTAL+2 lines, and raster_line always shows the current line number (11 bits).
- R4: disp_en is high exactly when the character count is at most H_DISP_END and the line count is at most V_DISP_END, provided the run bit is set and screen-off is clear.
- R5: hblank is high for character counts c with HB_START < c <= HB_END. vblank is high for line counts l with VB_START < l <= VB_END.
- R6: Horizontal sync turns on at the character equal to HS_START. It turns off at the first later character whose low 5 bits equal the 5-bit HS_END, so a pulse may span a line wrap. If both hold at once, start wins.
- R7: Vertical sync turns on at the line equal to VS_START. It turns off at the first later line whose low 4 bits equal the 4-bit VS_END.
- R8: In the polarity register, bit 6 set makes hsync active-low and bit 7 set makes vsync active-low. A change shows on the outputs from the next cycle.
- R9: In the power register, bit 0 is run, bit 7 holds hsync at its inactive level and bit 6 holds vsync at its inactive level. Bit 5 forces disp_en low while counters, blanking and raster_line continue.
- R10: A write to any timing register (addresses 0 to 12) during a running frame leaves the current frame unchanged and applies from the first line of the next frame. While stopped, such writes apply at once.
- R11: line_hit is high throughout the line whose count equals LINE_CMP.
- R12: Register addresses: 0 H_TOTAL, 1 H_DISP_END, 2 HB_START, 3 HB_END, 4 HS_START, 5 HS_END (5 bits), 6 V_TOTAL, 7 V_DISP_END, 8 VB_START, 9 VB_END, 10 VS_START, 11 VS_END (4 bits), 12 LINE_CMP, 13 polarity, 14 power. Horizontal values are 9 bits and vertical values are 11 bits, all taken from the low data bits. Address 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_ce | input | 1 | Pixel-clock enable, one per pixel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 11 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per register |
| vsync | output | 1 | Vertical sync, polarity per register |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_en | output | 1 | Active video strobe |
| raster_line | output | 11 | Current scanline |
| line_hit | output | 1 | High during the line-compare line |

## Verification
A short mode of 20 characters by 12 lines is run with pix_ce held high. Over one whole frame, the high-cycle counts of every strobe are compared against values worked out from the register settings. This separates errors in the offset biases, the strict-versus-inclusive blank bounds and the sync end matching.

A second mode places the horizontal sync start late in the line and the end value early, so the pulse must cross the line wrap through the truncated low-bit match. A write made mid-frame shows whether the shadow copy holds the line length until the wrap. A gapped pix_ce pattern tells a pixel-enable count apart from a clock count. An independent per-cycle model runs alongside all of these and follows every output.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int H_W         = 9;
    localparam int V_W         = 11;
    localparam int HSE_W       = 5;
    localparam int VSE_W       = 4;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 11;
    localparam int CHAR_PIX    = 8;
    localparam int H_TOTAL_OFS = 5;
    localparam int V_TOTAL_OFS = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_H_TOTAL  = 4'd0,
        RA_H_DEND   = 4'd1,
        RA_HB_START = 4'd2,
        RA_HB_END   = 4'd3,
        RA_HS_START = 4'd4,
        RA_HS_END   = 4'd5,
        RA_V_TOTAL  = 4'd6,
        RA_V_DEND   = 4'd7,
        RA_VB_START = 4'd8,
        RA_VB_END   = 4'd9,
        RA_VS_START = 4'd10,
        RA_VS_END   = 4'd11,
        RA_LINE_CMP = 4'd12,
        RA_POLARITY = 4'd13,
        RA_POWER    = 4'd14
    } reg_addr_e;

    typedef struct packed {
        logic [H_W-1:0]   total;
        logic [H_W-1:0]   disp_end;
        logic [H_W-1:0]   blank_s;
        logic [H_W-1:0]   blank_e;
        logic [H_W-1:0]   sync_s;
        logic [HSE_W-1:0] sync_e;
    } h_timing_t;

    typedef struct packed {
        logic [V_W-1:0]   total;
        logic [V_W-1:0]   disp_end;
        logic [V_W-1:0]   blank_s;
        logic [V_W-1:0]   blank_e;
        logic [V_W-1:0]   sync_s;
        logic [VSE_W-1:0] sync_e;
        logic [V_W-1:0]   line_cmp;
    } v_timing_t;

    typedef struct packed {
        logic hs_low;
        logic vs_low;
    } polarity_t;

    typedef struct packed {
        logic hs_off;
        logic vs_off;
        logic scr_off;
        logic run;
    } power_t;

    // drive level of a sync pin: active state, optionally inverted
    function automatic logic sync_level(input logic active, input logic gate_off,
                                        input logic low);
        return (active && !gate_off) ^ low;
    endfunction

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frame_load,
    output h_timing_t         h_act,
    output v_timing_t         v_act,
    output polarity_t         pol,
    output power_t            pwr
);

    h_timing_t h_sh;
    v_timing_t v_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_sh  <= '0;
            v_sh  <= '0;
            h_act <= '0;
            v_act <= '0;
            pol   <= '0;
            pwr   <= '0;
        end else begin
            // shadow set moves to the active set only at a frame boundary
            if (frame_load) begin
                h_act <= h_sh;
                v_act <= v_sh;
            end
            if (we) begin
                case (addr)
                    RA_H_TOTAL:  h_sh.total    <= wdata[H_W-1:0];
                    RA_H_DEND:   h_sh.disp_end <= wdata[H_W-1:0];
                    RA_HB_START: h_sh.blank_s  <= wdata[H_W-1:0];
                    RA_HB_END:   h_sh.blank_e  <= wdata[H_W-1:0];
                    RA_HS_START: h_sh.sync_s   <= wdata[H_W-1:0];
                    RA_HS_END:   h_sh.sync_e   <= wdata[HSE_W-1:0];
                    RA_V_TOTAL:  v_sh.total    <= wdata[V_W-1:0];
                    RA_V_DEND:   v_sh.disp_end <= wdata[V_W-1:0];
                    RA_VB_START: v_sh.blank_s  <= wdata[V_W-1:0];
                    RA_VB_END:   v_sh.blank_e  <= wdata[V_W-1:0];
                    RA_VS_START: v_sh.sync_s   <= wdata[V_W-1:0];
                    RA_VS_END:   v_sh.sync_e   <= wdata[VSE_W-1:0];
                    RA_LINE_CMP: v_sh.line_cmp <= wdata[V_W-1:0];
                    RA_POLARITY: pol <= '{hs_low: wdata[6], vs_low: wdata[7]};
                    RA_POWER:    pwr <= '{hs_off: wdata[7], vs_off: wdata[6],
                                          scr_off: wdata[5], run: wdata[0]};
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/crtc_axis.sv
module crtc_axis #(
    parameter int W    = 9,
    parameter int SE_W = 5,
    parameter int OFS  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick,
    input  logic [W-1:0]    total,
    input  logic [W-1:0]    disp_end,
    input  logic [W-1:0]    blank_s,
    input  logic [W-1:0]    blank_e,
    input  logic [W-1:0]    sync_s,
    input  logic [SE_W-1:0] sync_e,
    output logic [W:0]      cnt,
    output logic            at_last,
    output logic            in_disp,
    output logic            in_blank,
    output logic            sync_act
);

    localparam int CW = W + 1;

    logic [CW-1:0] last_val;
    logic [CW-1:0] nxt;

    // stored total carries a fixed bias; one extra bit holds the top count
    assign last_val = {1'b0, total} + CW'(OFS - 1);
    assign at_last  = (cnt == last_val);
    assign nxt      = at_last ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt      <= '0;
            sync_act <= 1'b0;
        end else if (tick) begin
            cnt <= nxt;
            if (nxt == {1'b0, sync_s})
                sync_act <= 1'b1;
            else if (nxt[SE_W-1:0] == sync_e)
                sync_act <= 1'b0;
        end
    end

    assign in_disp  = (cnt <= {1'b0, disp_end});
    assign in_blank = (cnt > {1'b0, blank_s}) && (cnt <= {1'b0, blank_e});

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_ce,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              disp_en,
    output logic [V_W-1:0]    raster_line,
    output logic              line_hit
);

    localparam int PX_W = $clog2(CHAR_PIX);

    h_timing_t h_act;
    v_timing_t v_act;
    polarity_t pol;
    power_t    pwr;

    logic            run;
    logic            char_tick;
    logic            frame_load;
    logic [PX_W-1:0] px;
    logic [H_W:0]    h_cnt;
    logic [V_W:0]    v_cnt;
    logic            h_last, v_last;
    logic            h_disp, v_disp;
    logic            h_blank, v_blank;
    logic            h_sync, v_sync;

    assign run        = pwr.run;
    assign char_tick  = run && pix_ce && (px == PX_W'(CHAR_PIX - 1));
    assign frame_load = !run || (char_tick && h_last && v_last);

    crtc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .frame_load (frame_load),
        .h_act      (h_act),
        .v_act      (v_act),
        .pol        (pol),
        .pwr        (pwr)
    );

    // pixel position inside the current character
    always_ff @(posedge clk) begin
        if (rst || !run)
            px <= '0;
        else if (pix_ce)
            px <= char_tick ? '0 : px + 1'b1;
    end

    crtc_axis #(.W(H_W), .SE_W(HSE_W), .OFS(H_TOTAL_OFS)) u_h (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (char_tick),
        .total    (h_act.total),
        .disp_end (h_act.disp_end),
        .blank_s  (h_act.blank_s),
        .blank_e  (h_act.blank_e),
        .sync_s   (h_act.sync_s),
        .sync_e   (h_act.sync_e),
        .cnt      (h_cnt),
        .at_last  (h_last),
        .in_disp  (h_disp),
        .in_blank (h_blank),
        .sync_act (h_sync)
    );

    crtc_axis #(.W(V_W), .SE_W(VSE_W), .OFS(V_TOTAL_OFS)) u_v (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (char_tick && h_last),
        .total    (v_act.total),
        .disp_end (v_act.disp_end),
        .blank_s  (v_act.blank_s),
        .blank_e  (v_act.blank_e),
        .sync_s   (v_act.sync_s),
        .sync_e   (v_act.sync_e),
        .cnt      (v_cnt),
        .at_last  (v_last),
        .in_disp  (v_disp),
        .in_blank (v_blank),
        .sync_act (v_sync)
    );

    assign hsync       = sync_level(h_sync, pwr.hs_off, pol.hs_low);
    assign vsync       = sync_level(v_sync, pwr.vs_off, pol.vs_low);
    assign hblank      = run && h_blank;
    assign vblank      = run && v_blank;
    assign disp_en     = run && !pwr.scr_off && h_disp && v_disp;
    assign raster_line = v_cnt[V_W-1:0];
    assign line_hit    = run && (v_cnt == {1'b0, v_act.line_cmp});

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic           char_tick,
    input logic           h_last,
    input logic [H_W:0]   h_cnt,
    input logic           frame_load,
    input h_timing_t      h_act,
    input v_timing_t      v_act,
    input polarity_t      pol,
    input power_t         pwr,
    input logic           hsync,
    input logic           vsync,
    input logic           disp_en,
    input logic           hblank,
    input logic           vblank,
    input logic [V_W-1:0] raster_line
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!disp_en && !hblank && !vblank));

    // R2
    char_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !char_tick) |=> $stable(h_cnt));

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !(char_tick && h_last)) |=> $stable(raster_line));

    // R4
    screen_off_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> !pwr.scr_off);

    // R9
    hsync_off_chk: assert property (@(posedge clk) disable iff (rst)
        pwr.hs_off |-> (hsync == pol.hs_low));

    // R9
    vsync_off_chk: assert property (@(posedge clk) disable iff (rst)
        pwr.vs_off |-> (vsync == pol.vs_low));

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_load |=> ($stable(h_act) && $stable(v_act)));

endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .char_tick   (char_tick),
    .h_last      (h_last),
    .h_cnt       (h_cnt),
    .frame_load  (frame_load),
    .h_act       (h_act),
    .v_act       (v_act),
    .pol         (pol),
    .pwr         (pwr),
    .hsync       (hsync),
    .vsync       (vsync),
    .disp_en     (disp_en),
    .hblank      (hblank),
    .vblank      (vblank),
    .raster_line (raster_line)
);

// File: tb/sim_crtc_timing_gen.sv
module sim_crtc_timing_gen;
    import crtc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_ce = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic              hsync, vsync, hblank, vblank, disp_en, line_hit;
    logic [V_W-1:0]    raster_line;

    int checks = 0;
    int fails  = 0;
    int mm     = 0;
    bit gap_mode = 1'b0;

    crtc_timing_gen u0 (
        .clk(clk), .rst(rst), .pix_ce(pix_ce), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hsync(hsync),
        .vsync(vsync), .hblank(hblank), .vblank(vblank), .disp_en(disp_en),
        .raster_line(raster_line), .line_hit(line_hit)
    );

    always #5 clk = ~clk;

    always @(negedge clk) pix_ce <= gap_mode ? ~pix_ce : 1'b1;

    // ---------------- reference model built from the requirements ----------
    int m_sh[15];
    int m_act[13];
    int m_px, m_hc, m_vc;
    bit m_hf, m_vf;

    function automatic int fmask(input int a);
        if (a == 5) return 31;
        if (a == 11) return 15;
        if (a <= 4) return 511;
        return 2047;
    endfunction

    always @(posedge clk) begin : model
        bit run, tick, hl, vl, ld;
        int nh, nv;
        if (rst) begin
            m_px = 0; m_hc = 0; m_vc = 0; m_hf = 0; m_vf = 0;
            for (int i = 0; i < 15; i++) m_sh[i] = 0;
            for (int i = 0; i < 13; i++) m_act[i] = 0;
        end else begin
            run  = m_sh[14][0];
            tick = run && pix_ce && (m_px == 7);
            hl   = (m_hc == m_act[0] + 4);
            vl   = (m_vc == m_act[6] + 1);
            ld   = !run || (tick && hl && vl);
            if (!run) begin
                m_px = 0; m_hc = 0; m_vc = 0; m_hf = 0; m_vf = 0;
            end else begin
                if (pix_ce) m_px = (m_px + 1) % 8;
                if (tick) begin
                    nh = hl ? 0 : m_hc + 1;
                    if (nh == m_act[4]) m_hf = 1;
                    else if ((nh % 32) == m_act[5]) m_hf = 0;
                    m_hc = nh;
                    if (hl) begin
                        nv = vl ? 0 : m_vc + 1;
                        if (nv == m_act[10]) m_vf = 1;
                        else if ((nv % 16) == m_act[11]) m_vf = 0;
                        m_vc = nv;
                    end
                end
            end
            if (ld) for (int i = 0; i < 13; i++) m_act[i] = m_sh[i];
            if (cfg_we && cfg_addr < 15)
                m_sh[cfg_addr] = int'(cfg_wdata) & fmask(int'(cfg_addr));
        end
    end

    always @(negedge clk) begin : compare
        bit run, e_hs, e_vs, e_de, e_hb, e_vb, e_lh;
        if (!rst) begin
            run  = m_sh[14][0];
            e_hs = (m_hf && !m_sh[14][7]) ^ m_sh[13][6];
            e_vs = (m_vf && !m_sh[14][6]) ^ m_sh[13][7];
            e_de = run && !m_sh[14][5] && m_hc <= m_act[1] && m_vc <= m_act[7];
            e_hb = run && m_hc > m_act[2] && m_hc <= m_act[3];
            e_vb = run && m_vc > m_act[8] && m_vc <= m_act[9];
            e_lh = run && m_vc == m_act[12];
            if (hsync !== e_hs || vsync !== e_vs || disp_en !== e_de ||
                hblank !== e_hb || vblank !== e_vb || line_hit !== e_lh ||
                raster_line !== m_vc[V_W-1:0])
                mm++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = ADDR_W'(a);
        cfg_wdata = DATA_W'(d);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic window(input int n, output int hs, output int vs, output int de,
                          output int hb, output int vb, output int lh, output int rc);
        logic [V_W-1:0] prev;
        hs = 0; vs = 0; de = 0; hb = 0; vb = 0; lh = 0; rc = 0;
        prev = raster_line;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hs += int'(hsync); vs += int'(vsync); de += int'(disp_en);
            hb += int'(hblank); vb += int'(vblank); lh += int'(line_hit);
            if (raster_line != prev) begin rc++; prev = raster_line; end
        end
    endtask

    task automatic measure_line(output int n);
        logic [V_W-1:0] r;
        @(negedge clk);
        r = raster_line;
        do @(negedge clk); while (raster_line == r);
        r = raster_line;
        n = 0;
        do begin @(negedge clk); n++; end while (raster_line == r);
    endtask

    task automatic check_model(input string tag);
        chk(tag, "model mismatch cycles", mm, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int hs, vs, de, hb, vb, lh, rc;
        @(negedge clk);
        chk("R1", "hsync after reset", int'(hsync), 0);
        chk("R1", "vsync after reset", int'(vsync), 0);
        chk("R1", "disp_en after reset", int'(disp_en), 0);
        chk("R1", "blank after reset", int'(hblank | vblank), 0);
        chk("R1", "raster after reset", int'(raster_line), 0);
        window(50, hs, vs, de, hb, vb, lh, rc);
        chk("R1", "activity while stopped", hs + vs + de + hb + vb + lh + rc, 0);
    endtask

    task automatic t_basic();
        int hs, vs, de, hb, vb, lh, rc, n;
        // 20 chars x 12 lines; R12 address map
        wr(0, 15); wr(1, 9); wr(2, 9); wr(3, 19); wr(4, 12); wr(5, 16);
        wr(6, 10); wr(7, 5); wr(8, 5); wr(9, 11); wr(10, 7); wr(11, 9); wr(12, 6);
        wr(14, 'h001);
        window(1920, hs, vs, de, hb, vb, lh, rc);
        chk("R6", "hsync cycles/frame", hs, 384);
        chk("R7", "vsync cycles/frame", vs, 320);
        chk("R4", "disp_en cycles/frame", de, 480);
        chk("R5", "hblank cycles/frame", hb, 960);
        chk("R5", "vblank cycles/frame", vb, 960);
        chk("R11", "line_hit cycles/frame", lh, 160);
        chk("R3", "raster changes/frame", rc, 12);
        measure_line(n);
        chk("R2", "line length cycles", n, 160);
        check_model("R12");
    endtask

    task automatic t_polarity();
        int hs, vs, de, hb, vb, lh, rc;
        wr(13, 'h0C0);
        window(1920, hs, vs, de, hb, vb, lh, rc);
        chk("R8", "hsync high, active-low", hs, 1536);
        chk("R8", "vsync high, active-low", vs, 1600);
        check_model("R8");
    endtask

    task automatic t_power();
        int hs, vs, de, hb, vb, lh, rc;
        wr(14, 'h081);
        window(1920, hs, vs, de, hb, vb, lh, rc);
        chk("R9", "hsync held idle", hs, 1920);
        chk("R9", "vsync unaffected", vs, 1600);
        wr(14, 'h041);
        window(1920, hs, vs, de, hb, vb, lh, rc);
        chk("R9", "vsync held idle", vs, 1920);
        chk("R9", "hsync unaffected", hs, 1536);
        wr(14, 'h021);
        window(1920, hs, vs, de, hb, vb, lh, rc);
        chk("R9", "disp_en with screen off", de, 0);
        chk("R9", "hblank with screen off", hb, 960);
        chk("R9", "raster runs with screen off", rc, 12);
        wr(14, 'h001);
        wr(13, 'h000);
        check_model("R9");
    endtask

    task automatic t_shadow();
        int n;
        do @(negedge clk); while (raster_line != 2);
        wr(0, 23);
        measure_line(n);
        chk("R10", "line length before wrap", n, 160);
        do @(negedge clk); while (raster_line != 0);
        n = 0;
        do begin @(negedge clk); n++; end while (raster_line == 0);
        chk("R10", "line length after wrap", n, 224);
        check_model("R10");
    endtask

    task automatic t_long_sync();
        int hs, vs, de, hb, vb, lh, rc;
        wr(14, 'h000); wr(4, 20); wr(5, 3); wr(14, 'h001);
        repeat (2688) @(negedge clk);
        window(2688, hs, vs, de, hb, vb, lh, rc);
        chk("R6", "hsync across line wrap", hs, 1056);
        chk("R7", "vsync on 28-char lines", vs, 448);
        chk("R4", "disp_en on 28-char lines", de, 480);
        chk("R11", "line_hit on 28-char lines", lh, 224);
        check_model("R6");
    endtask

    task automatic t_gapped();
        int n;
        gap_mode = 1'b1;
        measure_line(n);
        chk("R2", "line length with gapped pix_ce", n, 448);
        gap_mode = 1'b0;
        check_model("R2");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_polarity();
        t_power();
        t_shadow();
        t_long_sync();
        t_gapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule